// File: doc/BRIEF.md
# Bus Controller Frame Sequencer

This block paces a bus controller through a frame of messages. Software loads a starting stack pointer and a message count, then issues a start command. The sequencer sends the message engine a one-cycle start pulse for each message. It waits for the engine's done handshake, decrements the count and advances the pointer. It spaces consecutive starts by a start-to-start gap that is given separately for each message in whole microseconds. When the count runs out, the frame is over.

In single-frame mode the sequencer then goes idle. In repeat mode it waits for the next frame trigger. That trigger is either the expiry of an internal periodic frame timer, which counts in steps of `FRAME_STEP_US` microseconds, or a rising edge on an external trigger pin. Each repeated frame reloads the pointer and count from the initial-value inputs as they stand at that moment. A trigger that arrives while a frame is still running does not start a frame; it sets a sticky overrun flag instead.

Top module: `bc_frame_seq`

## Requirements
- R1: While reset is asserted and after it is released, frame_start_o, msg_start_o, busy_o and overrun_o are 0, and stack_ptr_o and msg_cnt_o are 0.
- R2: A start_i pulse sampled at clock edge E while not busy pulses frame_start_o after E. At the same edge, stack_ptr_o and msg_cnt_o load init_ptr_i and init_cnt_i. The first msg_start_o pulse follows at edge E+1.
- R3: gap_i is sampled at the edge that raises msg_start_o. If the message finishes early, the next msg_start_o rises exactly gap_i*TICKS_PER_US cycles after the previous one.
- R4: If msg_done_i arrives after the gap has run out, the next msg_start_o rises at the same edge that samples msg_done_i.
- R5: Each accepted msg_done_i decrements msg_cnt_o by 1 and adds PTR_STEP to stack_ptr_o. A msg_done_i that arrives when no message is running changes neither value.
- R6: The done that brings msg_cnt_o to 0 ends the frame with no further msg_start_o. In single-frame mode (auto_rpt_i=0), busy_o is 0 from that edge on.
- R7: With auto_rpt_i=1 and ext_sel_i=0, frames start every frame_time_i*TICKS_PER_US*FRAME_STEP_US cycles, counted from the accepted start_i. Each frame reloads the pointer and count from the init inputs.
- R8: With auto_rpt_i=1 and ext_sel_i=1, a new frame starts only on a rising edge of ext_trig_i. A level held high starts one frame, and the internal timer is ignored.
- R9: A frame trigger while busy_o=1 in repeat mode sets overrun_o and leaves the running frame unchanged. overrun_o stays 1 until the next accepted start_i clears it.
- R10: A frame start with init_cnt_i=0 pulses frame_start_o but issues no msg_start_o and leaves busy_o at 0.
- R11: A gap of 0 lets the next msg_start_o rise at the edge that samples the previous message's done.
- R12: Dropping auto_rpt_i while waiting for a trigger returns the block to idle, and no further frame starts.
- R13: A start_i pulse while busy_o=1 is ignored: no frame_start_o, and the pointer and count are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command pulse |
| auto_rpt_i | input | 1 | 1 = repeat frames, 0 = single frame |
| ext_sel_i | input | 1 | 1 = external trigger paces frames, 0 = internal timer |
| ext_trig_i | input | 1 | External frame trigger (rising edge) |
| gap_i | input | GAP_W | Start-to-start gap of the message being started, in microseconds |
| frame_time_i | input | FRAME_W | Frame period in FRAME_STEP_US units, taken at start_i |
| init_ptr_i | input | PTR_W | Initial stack pointer |
| init_cnt_i | input | $clog2(MAX_MSGS+1) | Initial message count |
| msg_done_i | input | 1 | Message engine finished the current message |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| msg_start_o | output | 1 | One-cycle pulse starting a message |
| busy_o | output | 1 | A frame is running |
| overrun_o | output | 1 | Sticky: a trigger arrived while a frame was running |
| stack_ptr_o | output | PTR_W | Current stack pointer |
| msg_cnt_o | output | $clog2(MAX_MSGS+1) | Messages still to be completed |

## Verification
The bench drives frames whose messages finish early, exactly on time or late relative to their gaps. This separates pure gap pacing from starts that wait on a done handshake. It also runs a zero gap and an empty frame. Repeat mode is tried with an internal period longer than the frame, which shows reload from init values that change between frames. It is also tried with a period shorter than the frame, which shows overrun without disturbing the running frame. A held external trigger level tells edge detection apart from level sensing. Done pulses and start commands given at the wrong time show that those inputs are ignored.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/bc_interval_timer.sv
// Down-counter in units of UNIT_TICKS clocks. The prescaler restarts on every
// load, so the expiry lands exactly value*UNIT_TICKS edges after the load edge.
module bc_interval_timer #(
   parameter int CNT_W      = 16,
   parameter int UNIT_TICKS = 50,
   parameter bit PERIODIC   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   output logic             idle_o,
   output logic             fire_o
);
   localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

   if (UNIT_TICKS < 1) begin : g_bad_unit
      $error("bc_interval_timer: UNIT_TICKS must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] remain_q;
   logic             run_q;
   logic [CNT_W-1:0] wrap_val;
   logic             wrap_run;
   logic             unit_end;

   if (PERIODIC) begin : g_periodic
      logic [CNT_W-1:0] period_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      period_q <= '0;
         else if (load_i) period_q <= value_i;
      end
      assign wrap_val = period_q;
      assign wrap_run = 1'b1;
   end else begin : g_oneshot
      assign wrap_val = '0;
      assign wrap_run = 1'b0;
   end

   assign unit_end = (pre_q == PRE_LAST);
   assign fire_o   = run_q && unit_end && (remain_q == CNT_W'(1));
   assign idle_o   = !run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q    <= '0;
         remain_q <= '0;
         run_q    <= 1'b0;
      end else if (load_i) begin
         pre_q    <= '0;
         remain_q <= value_i;
         run_q    <= (value_i != '0);
      end else if (run_q) begin
         if (unit_end) begin
            pre_q <= '0;
            if (remain_q == CNT_W'(1)) begin
               remain_q <= wrap_val;
               run_q    <= wrap_run;
            end else begin
               remain_q <= remain_q - CNT_W'(1);
            end
         end else begin
            pre_q <= pre_q + PRE_W'(1);
         end
      end
   end

   AST_TMR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (remain_q != '0)); // R3
endmodule

// File: rtl/bc_trig_select.sv
// Picks the frame trigger source; EDGE_DETECT chooses edge or level sensing.
module bc_trig_select #(
   parameter bit EDGE_DETECT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_i,
   input  logic ext_sel_i,
   input  logic int_fire_i,
   output logic trig_o
);
   logic ext_ev;

   if (EDGE_DETECT) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= ext_i;
      end
      assign ext_ev = ext_i && !prev_q;

      AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         ext_ev |=> !ext_ev); // R8
   end else begin : g_level
      assign ext_ev = ext_i;
   end

   assign trig_o = ext_sel_i ? ext_ev : int_fire_i;
endmodule

// File: rtl/bc_msg_tracker.sv
// Holds the stack pointer and the remaining-message count.
module bc_msg_tracker #(
   parameter int PTR_W    = 16,
   parameter int CNT_W    = 10,
   parameter int PTR_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] init_ptr_i,
   input  logic [CNT_W-1:0] init_cnt_i,
   input  logic             step_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);
   if (PTR_STEP < 1) begin : g_bad_step
      $error("bc_msg_tracker: PTR_STEP must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_o <= '0;
         cnt_o <= '0;
      end else if (load_i) begin
         ptr_o <= init_ptr_i;
         cnt_o <= init_cnt_i;
      end else if (step_i) begin
         ptr_o <= ptr_o + PTR_W'(PTR_STEP);
         cnt_o <= cnt_o - CNT_W'(1);
      end
   end

   assign last_o = (cnt_o == CNT_W'(1));

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1))); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (cnt_o != '0)); // R6
endmodule

// File: rtl/bc_frame_seq.sv
module bc_frame_seq
   import bc_seq_pkg::*;
#(
   parameter int MAX_MSGS      = 512,
   parameter int GAP_W         = 16,
   parameter int FRAME_W       = 16,
   parameter int PTR_W         = 16,
   parameter int PTR_STEP      = 4,
   parameter int TICKS_PER_US  = 50,
   parameter int FRAME_STEP_US = 100,
   parameter bit EXT_EDGE      = 1'b1,
   localparam int MCNT_W       = $clog2(MAX_MSGS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               auto_rpt_i,
   input  logic               ext_sel_i,
   input  logic               ext_trig_i,
   input  logic [GAP_W-1:0]   gap_i,
   input  logic [FRAME_W-1:0] frame_time_i,
   input  logic [PTR_W-1:0]   init_ptr_i,
   input  logic [MCNT_W-1:0]  init_cnt_i,
   input  logic               msg_done_i,
   output logic               frame_start_o,
   output logic               msg_start_o,
   output logic               busy_o,
   output logic               overrun_o,
   output logic [PTR_W-1:0]   stack_ptr_o,
   output logic [MCNT_W-1:0]  msg_cnt_o
);
   localparam int FRAME_TICKS = TICKS_PER_US * FRAME_STEP_US;

   if (MAX_MSGS < 1) begin : g_bad_max
      $error("bc_frame_seq: MAX_MSGS must be at least 1");
   end
   if (TICKS_PER_US < 1 || FRAME_STEP_US < 1) begin : g_bad_rate
      $error("bc_frame_seq: tick rates must be positive");
   end

   seq_state_e state_q;
   logic       active_q;
   logic       gap_idle, gap_fire, gap_due;
   logic       frm_idle, frm_fire, frm_trig;
   logic       last_msg;
   logic       start_ok, auto_ev, frame_go, done_acc, issue, end_frame;
   seq_state_e end_state;

   // ---------------- timers and trigger selection ----------------
   bc_interval_timer #(
      .CNT_W(GAP_W), .UNIT_TICKS(TICKS_PER_US), .PERIODIC(1'b0)
   ) u_gap_tmr (
      .clk(clk), .rst_n(rst_n),
      .load_i(issue || frame_go),
      .value_i(frame_go ? '0 : gap_i),
      .idle_o(gap_idle), .fire_o(gap_fire)
   );

   bc_interval_timer #(
      .CNT_W(FRAME_W), .UNIT_TICKS(FRAME_TICKS), .PERIODIC(1'b1)
   ) u_frm_tmr (
      .clk(clk), .rst_n(rst_n),
      .load_i(start_ok), .value_i(frame_time_i),
      .idle_o(frm_idle), .fire_o(frm_fire)
   );

   bc_trig_select #(.EDGE_DETECT(EXT_EDGE)) u_trig (
      .clk(clk), .rst_n(rst_n),
      .ext_i(ext_trig_i), .ext_sel_i(ext_sel_i),
      .int_fire_i(frm_fire), .trig_o(frm_trig)
   );

   bc_msg_tracker #(
      .PTR_W(PTR_W), .CNT_W(MCNT_W), .PTR_STEP(PTR_STEP)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .load_i(frame_go), .init_ptr_i(init_ptr_i), .init_cnt_i(init_cnt_i),
      .step_i(done_acc),
      .ptr_o(stack_ptr_o), .cnt_o(msg_cnt_o), .last_o(last_msg)
   );

   // ---------------- sequencing decisions ----------------
   always_comb begin
      gap_due   = gap_idle || gap_fire;
      start_ok  = start_i && (state_q != SEQ_RUN);
      auto_ev   = auto_rpt_i && frm_trig;
      frame_go  = start_ok || ((state_q == SEQ_WAIT) && auto_ev);
      done_acc  = msg_done_i && active_q && (state_q == SEQ_RUN);
      end_frame = done_acc && last_msg;
      issue     = (state_q == SEQ_RUN) && gap_due &&
                  (!active_q || done_acc) && !end_frame;
      end_state = auto_rpt_i ? SEQ_WAIT : SEQ_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= SEQ_IDLE;
         active_q      <= 1'b0;
         msg_start_o   <= 1'b0;
         frame_start_o <= 1'b0;
         overrun_o     <= 1'b0;
      end else begin
         msg_start_o   <= issue;
         frame_start_o <= frame_go;

         if (frame_go)
            state_q <= (init_cnt_i == '0) ? end_state : SEQ_RUN;
         else if (state_q == SEQ_RUN && end_frame)
            state_q <= end_state;
         else if (state_q == SEQ_WAIT && !auto_rpt_i)
            state_q <= SEQ_IDLE;

         if (frame_go)      active_q <= 1'b0;
         else if (issue)    active_q <= 1'b1;
         else if (done_acc) active_q <= 1'b0;

         if (start_ok)                             overrun_o <= 1'b0;
         else if (state_q == SEQ_RUN && auto_ev)   overrun_o <= 1'b1;
      end
   end

   assign busy_o = (state_q == SEQ_RUN);

   // ---------------- assertions ----------------
   AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start_o |=> !msg_start_o); // R3
   AST_GAP_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      gap_fire |=> (gap_idle || msg_start_o)); // R3
   AST_MSG_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start_o |-> busy_o); // R2
   AST_BUSY_HAS_MSGS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (msg_cnt_o != '0)); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> !msg_start_o); // R6
   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !start_i) |=> overrun_o); // R9
   AST_FRM_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
      frm_fire |=> !frm_idle); // R7
   AST_INIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |-> (int'(init_cnt_i) <= MAX_MSGS)); // R2
endmodule

// File: tb/sim_bc_frame_seq.sv
module sim_bc_frame_seq;
   localparam int CLK_PERIOD = 10;
   localparam int T_US       = 2;
   localparam int F_US       = 4;
   localparam int STEP       = 4;
   localparam int CW         = 10;

   logic           clk, rst_n, start_i, auto_rpt_i, ext_sel_i, ext_trig_i;
   logic [15:0]    gap_i, frame_time_i, init_ptr_i;
   logic [CW-1:0]  init_cnt_i;
   logic           msg_done_i, eng_done, man_done;
   logic           frame_start_o, msg_start_o, busy_o, overrun_o;
   logic [15:0]    stack_ptr_o;
   logic [CW-1:0]  msg_cnt_o;

   assign msg_done_i = eng_done | man_done;

   bc_frame_seq #(
      .MAX_MSGS(512), .GAP_W(16), .FRAME_W(16), .PTR_W(16), .PTR_STEP(STEP),
      .TICKS_PER_US(T_US), .FRAME_STEP_US(F_US), .EXT_EDGE(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_rpt_i(auto_rpt_i),
      .ext_sel_i(ext_sel_i), .ext_trig_i(ext_trig_i), .gap_i(gap_i),
      .frame_time_i(frame_time_i), .init_ptr_i(init_ptr_i),
      .init_cnt_i(init_cnt_i), .msg_done_i(msg_done_i),
      .frame_start_o(frame_start_o), .msg_start_o(msg_start_o),
      .busy_o(busy_o), .overrun_o(overrun_o),
      .stack_ptr_o(stack_ptr_o), .msg_cnt_o(msg_cnt_o)
   );

   typedef struct { int cyc; int ptr; int cnt; } ev_t;
   ev_t msg_q[$];
   int  frm_q[$];
   int  gap_tab[8];
   int  len_tab[8];
   int  cyc = 0;
   int  total = 0;
   int  bad = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // expected frame and message starts, computed from the requirements
   task automatic plan_frame(input int e, input int n, input int p0, output int endc);
      int s, d;
      frm_q.push_back(e);
      endc = e;
      s = e + 1;
      for (int k = 0; k < n; k++) begin
         ev_t ev;
         ev.cyc = s; ev.ptr = p0 + k*STEP; ev.cnt = n - k;
         msg_q.push_back(ev);
         d = s + len_tab[k] + 1;
         endc = d;
         if (k < n-1) s = (s + gap_tab[k]*T_US > d) ? s + gap_tab[k]*T_US : d;
      end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic launch(input int n, input int p0, output int e, output int endc);
      @(negedge clk);
      e = cyc + 1;
      init_cnt_i = CW'(n);
      init_ptr_i = 16'(p0);
      plan_frame(e, n, p0, endc);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // monitor: pops the scoreboard as the design produces events
   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_start_o) begin
            if (frm_q.size() == 0) chk(1'b0, "R2", "unexpected frame start", cyc, -1);
            else begin
               int e;
               e = frm_q.pop_front();
               chk(e == cyc, "R2", "frame start cycle", cyc, e);
            end
         end
         if (msg_start_o) begin
            if (msg_q.size() == 0) chk(1'b0, "R6", "unexpected message start", cyc, -1);
            else begin
               ev_t x;
               x = msg_q.pop_front();
               chk(x.cyc == cyc, "R3", "message start cycle", cyc, x.cyc);
               chk(x.ptr == int'(stack_ptr_o), "R5", "pointer at start", int'(stack_ptr_o), x.ptr);
               chk(x.cnt == int'(msg_cnt_o), "R5", "count at start", int'(msg_cnt_o), x.cnt);
            end
         end
      end
   end

   // message engine model: done after len_tab[k] idle cycles
   initial begin
      int idx;
      bit again;
      idx = 0;
      eng_done = 1'b0;
      forever begin
         @(negedge clk);
         again = 1'b1;
         while (again) begin
            again = 1'b0;
            if (frame_start_o) begin
               idx = 0;
               gap_i = 16'(gap_tab[0]);
            end
            if (msg_start_o) begin
               idx++;
               gap_i = 16'(gap_tab[idx % 8]);
               repeat (len_tab[idx-1]) @(negedge clk);
               eng_done = 1'b1;
               @(negedge clk);
               eng_done = 1'b0;
               again = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int e, endc;
      rst_n = 1'b0; start_i = 1'b0; auto_rpt_i = 1'b0; ext_sel_i = 1'b0;
      ext_trig_i = 1'b0; gap_i = '0; frame_time_i = '0; init_ptr_i = '0;
      init_cnt_i = '0; man_done = 1'b0;
      for (int i = 0; i < 8; i++) begin gap_tab[i] = 0; len_tab[i] = 0; end
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(frame_start_o == 0 && msg_start_o == 0, "R1", "start pulses in reset", int'(msg_start_o), 0);
      chk(busy_o == 0 && overrun_o == 0, "R1", "busy/overrun in reset", int'(busy_o), 0);
      chk(stack_ptr_o == 0 && msg_cnt_o == 0, "R1", "pointer/count in reset", int'(stack_ptr_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && msg_cnt_o == 0, "R1", "state after reset", int'(busy_o), 0);

      // single frame: early, late and on-time completions (R2 R3 R4 R5 R6 R13)
      gap_tab[0] = 5; gap_tab[1] = 3; gap_tab[2] = 4;
      len_tab[0] = 2; len_tab[1] = 9; len_tab[2] = 1;
      launch(3, 100, e, endc);
      chk(int'(stack_ptr_o) == 100 && int'(msg_cnt_o) == 3, "R2", "load at frame start", int'(stack_ptr_o), 100);
      wait_until(e + 2);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1 && int'(msg_cnt_o) == 3, "R13", "count after ignored start", int'(msg_cnt_o), 3);
      chk(int'(stack_ptr_o) == 100, "R13", "pointer after ignored start", int'(stack_ptr_o), 100);
      wait_until(endc);
      chk(busy_o == 0, "R6", "busy after last done", int'(busy_o), 0);
      chk(int'(stack_ptr_o) == 112 && msg_cnt_o == 0, "R5", "pointer at frame end", int'(stack_ptr_o), 112);
      repeat (3) @(negedge clk);
      man_done = 1'b1;
      @(negedge clk);
      man_done = 1'b0;
      @(negedge clk);
      chk(int'(stack_ptr_o) == 112 && msg_cnt_o == 0, "R5", "stray done while idle", int'(stack_ptr_o), 112);

      // zero gap (R11)
      gap_tab[0] = 0; gap_tab[1] = 0; len_tab[0] = 3; len_tab[1] = 0;
      launch(2, 0, e, endc);
      wait_until(endc + 2);
      chk(busy_o == 0 && int'(stack_ptr_o) == 8, "R11", "zero-gap frame end", int'(stack_ptr_o), 8);

      // empty frame (R10)
      launch(0, 7, e, endc);
      chk(busy_o == 0 && msg_cnt_o == 0, "R10", "empty frame not busy", int'(busy_o), 0);
      repeat (20) @(negedge clk);
      chk(busy_o == 0, "R10", "empty frame stays idle", int'(busy_o), 0);

      // repeat mode, internal timer, reload from changing init values (R7 R12)
      auto_rpt_i = 1'b1; ext_sel_i = 1'b0; frame_time_i = 16'd10;
      gap_tab[0] = 5; gap_tab[1] = 5; len_tab[0] = 2; len_tab[1] = 2;
      launch(2, 200, e, endc);
      plan_frame(e + 80, 2, 300, endc);
      plan_frame(e + 160, 2, 400, endc);
      wait_until(e + 40);
      init_ptr_i = 16'd300;
      wait_until(e + 120);
      init_ptr_i = 16'd400;
      wait_until(e + 200);
      chk(busy_o == 0 && overrun_o == 0, "R7", "waiting between frames", int'(overrun_o), 0);
      auto_rpt_i = 1'b0;
      wait_until(e + 260);
      chk(busy_o == 0 && frm_q.size() == 0, "R12", "no frame after leaving repeat", frm_q.size(), 0);

      // overrun: period shorter than frame (R9)
      auto_rpt_i = 1'b1; frame_time_i = 16'd2;
      gap_tab[0] = 10; gap_tab[1] = 10; len_tab[0] = 2; len_tab[1] = 2;
      launch(2, 0, e, endc);
      plan_frame(e + 32, 2, 0, endc);
      wait_until(e + 15);
      chk(overrun_o == 0, "R9", "overrun before trigger", int'(overrun_o), 0);
      wait_until(e + 16);
      chk(overrun_o == 1 && busy_o == 1, "R9", "overrun on trigger in frame", int'(overrun_o), 1);
      wait_until(e + 50);
      auto_rpt_i = 1'b0;
      wait_until(e + 70);
      chk(overrun_o == 1 && busy_o == 0, "R9", "overrun sticky", int'(overrun_o), 1);

      // external trigger, level held high (R8) ; start clears overrun (R9)
      auto_rpt_i = 1'b1; ext_sel_i = 1'b1; frame_time_i = 16'd1;
      gap_tab[0] = 0; len_tab[0] = 2;
      launch(1, 50, e, endc);
      chk(overrun_o == 0, "R9", "start clears overrun", int'(overrun_o), 0);
      plan_frame(e + 10, 1, 50, endc);
      plan_frame(e + 30, 1, 50, endc);
      wait_until(e + 9);
      ext_trig_i = 1'b1;
      wait_until(e + 12);
      ext_trig_i = 1'b0;
      wait_until(e + 29);
      ext_trig_i = 1'b1;
      @(negedge clk);
      ext_trig_i = 1'b0;
      wait_until(e + 40);
      auto_rpt_i = 1'b0;
      wait_until(e + 60);
      chk(overrun_o == 0 && busy_o == 0, "R8", "held level gave one frame", int'(overrun_o), 0);

      chk(msg_q.size() == 0, "R3", "message starts left unseen", msg_q.size(), 0);
      chk(frm_q.size() == 0, "R7", "frame starts left unseen", frm_q.size(), 0);
      finish_run();
   end
endmodule